// File: doc/BRIEF.md
# Power-Off Request Arbiter and Sequencer

This block makes the shutdown decisions inside a power-management state controller. Nine shutdown sources feed it: thermal shutdown, a software reset bit, a low system-voltage event, a pair of keep-alive holders (a register bit and a pin), a long-press power button, a power-down pin, a watchdog timeout, an active-low reset pin and an ADC shutdown event. Each source is qualified by its own debounce, mask or enable rule. No sleep or on request can block a qualified source.

The four urgent sources act at once. The others wait for a shared switch-off delay, counted in millisecond ticks. When the block commits, it latches the winning source together with that source's reset-level and restart choices, and pulses a power-down start toward the regulator sequencer. Once the device reports OFF, the block holds off new on requests until the winning source is released. For a source configured to restart, it then pulses a power-up start as soon as the external on-gating flag is low.

Top module: `pwroff_arb`

## Requirements
- R1: The urgent sources (thermal, software reset, low system voltage, keep-alive) raise `pwrdn_start` on the first clock edge after they are seen while `cur_state` is ACTIVE (2'b01) or SLEEP (2'b10). `on_gate` has no effect on this. While `cur_state` is OFF (2'b00), no source starts a power-down.
- R2: Delayed sources fire after a number of `ms_tick` pulses set by `cfg_dly_sel`: 0, 1, 2 or 3 selects 0, MS_PER_S, 2*MS_PER_S or 4*MS_PER_S. The power-down pin is filtered in both directions by `cfg_pdn_db_ms` ticks.
- R3: When several sources are qualified together, the lowest `win_src` code wins. The codes are 0 thermal, 1 software reset, 2 low voltage, 3 keep-alive, 4 button, 5 power-down pin, 6 watchdog, 7 reset pin, 8 ADC.
- R4: The winner's bit in `cfg_wide` is latched to `wide_rst` (1 = wide register reset, 0 = limited reset). The winner's bit in `cfg_restart` chooses cold restart (1) or plain shutdown (0).
- R5: The keep-alive source is active only when `dev_on_bit` and `hold_pin` are both low. It always gives the limited reset and a plain shutdown, whatever its configuration bits hold.
- R6: The button `pwrbtn_n` is active low. It qualifies after it has been held low for `cfg_lpk_ms` ticks.
- R7: The reset pin `reset_in_n` is active low. It qualifies after RST_ASSERT_MS ticks low (default 1). It is released only after RST_RELEASE_MS ticks high (default 26).
- R8: The ADC shutdown source is ignored while `cfg_adc_mask` is 1. It is the only source that can be masked.
- R9: The watchdog source is disabled after reset. A write through `wdt_en_wr` sets the enable. `wdt_lock_wr` locks it until reset, and enable writes made while locked are ignored.
- R10: After power-down, `on_allow` stays low until the winning source clears. If a restart was chosen, `pwrup_start` then pulses at the first edge with `on_gate` low.
- R11: While a delay runs, a newly seen urgent source fires on the next edge with its own configuration. A delayed source that is withdrawn cancels the countdown.
- R12: `pwrdn_start` and `pwrup_start` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| cur_state | input | 2 | Controller state: 00 OFF, 01 ACTIVE, 10 SLEEP, 11 in transition |
| on_gate | input | 1 | High while an on-gating condition is present |
| thermal_sd | input | 1 | Thermal shutdown event |
| sw_rst_bit | input | 1 | Software reset register bit |
| vsys_low | input | 1 | Low system voltage event |
| dev_on_bit | input | 1 | Device-on register bit (keep-alive) |
| hold_pin | input | 1 | Power-hold pin (keep-alive) |
| pwrbtn_n | input | 1 | Power button, active low |
| pdn_pin | input | 1 | Power-down pin, active high |
| wdt_expire | input | 1 | Watchdog timeout event |
| reset_in_n | input | 1 | Reset pin, active low |
| adc_sd | input | 1 | ADC shutdown event |
| cfg_dly_sel | input | 2 | Switch-off delay select |
| cfg_lpk_ms | input | CW | Long-press time in ticks |
| cfg_pdn_db_ms | input | CW | Power-down pin debounce in ticks |
| cfg_adc_mask | input | 1 | Mask for the ADC shutdown source |
| cfg_wide | input | 9 | Per-source wide reset choice |
| cfg_restart | input | 9 | Per-source cold restart choice |
| wdt_en_wr | input | 1 | Watchdog enable write strobe |
| wdt_en_val | input | 1 | Watchdog enable write value |
| wdt_lock_wr | input | 1 | Watchdog lock strobe |
| pwrdn_start | output | 1 | Power-down sequence start pulse |
| pwrup_start | output | 1 | OFF-to-ACTIVE sequence start pulse |
| wide_rst | output | 1 | Latched reset level, 1 = wide |
| win_src | output | 4 | Latched winning source code |
| on_allow | output | 1 | High when new on requests may be served |

## Verification
The delay counter can expire on the same edge that an urgent source appears. To provoke this, the bench lets a delayed power-down pin count down to its last tick and raises thermal shutdown in that same cycle. The pulse that results must carry the thermal code and the thermal reset level, not the pin's. The same bench also stacks three sources in one cycle to judge priority, then releases the winner to show that the next source in line takes over.

// File: rtl/pwroff_pkg.sv
// Shared constants and types for the power-off arbiter.
// Assumes source codes below N_IMM are the urgent, undelayed ones.
package pwroff_pkg;
    localparam int NREQ  = 9;
    localparam int SRC_W = 4;
    localparam int N_IMM = 4;

    localparam int SRC_THERM  = 0;
    localparam int SRC_SWRST  = 1;
    localparam int SRC_VSYS   = 2;
    localparam int SRC_KEEP   = 3;
    localparam int SRC_BTN    = 4;
    localparam int SRC_PDPIN  = 5;
    localparam int SRC_WDT    = 6;
    localparam int SRC_RSTPIN = 7;
    localparam int SRC_ADC    = 8;

    typedef enum logic [1:0] {
        PS_OFF    = 2'b00,
        PS_ACTIVE = 2'b01,
        PS_SLEEP  = 2'b10,
        PS_TRANS  = 2'b11
    } pstate_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_WAIT,
        SQ_PDN,
        SQ_OFFW,
        SQ_RSTW
    } seq_e;
endpackage

// File: rtl/pwroff_debounce.sv
// Level filter with separate assert and release times in ms ticks.
// The output follows the input once it has differed for the active
// threshold; a threshold of zero follows on the next edge.
module pwroff_debounce #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ms_tick,
    input  logic          raw,
    input  logic [CW-1:0] rise_ms,
    input  logic [CW-1:0] fall_ms,
    output logic          filt
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] thr;
    logic [CW:0]   cnt_nxt;
    logic          done;

    // Select the threshold for the direction of the pending change.
    always_comb begin
        thr     = filt ? fall_ms : rise_ms;
        cnt_nxt = {1'b0, cnt} + 1'b1;
        done    = (thr == '0) || (ms_tick && (cnt_nxt >= {1'b0, thr}));
    end

    // Count ticks of disagreement and flip when the threshold is met.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt <= 1'b0;
            cnt  <= '0;
        end else if (raw == filt) begin
            cnt <= '0;
        end else if (done) begin
            filt <= raw;
            cnt  <= '0;
        end else if (ms_tick) begin
            cnt <= cnt_nxt[CW-1:0];
        end
    end
endmodule

// File: rtl/pwroff_qual.sv
// Turns raw shutdown sources into a qualified request vector.
// It applies polarity, debounce, the ADC mask and the lockable watchdog
// enable. It assumes all inputs are already synchronous to clk.
module pwroff_qual import pwroff_pkg::*; #(
    parameter int CW             = 8,
    parameter int RST_ASSERT_MS  = 1,
    parameter int RST_RELEASE_MS = 26
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ms_tick,
    input  logic            thermal_sd,
    input  logic            sw_rst_bit,
    input  logic            vsys_low,
    input  logic            dev_on_bit,
    input  logic            hold_pin,
    input  logic            pwrbtn_n,
    input  logic            pdn_pin,
    input  logic            wdt_expire,
    input  logic            reset_in_n,
    input  logic            adc_sd,
    input  logic [CW-1:0]   cfg_lpk_ms,
    input  logic [CW-1:0]   cfg_pdn_db_ms,
    input  logic            cfg_adc_mask,
    input  logic            wdt_en_wr,
    input  logic            wdt_en_val,
    input  logic            wdt_lock_wr,
    output logic [NREQ-1:0] qreq,
    output logic            wdt_en,
    output logic            wdt_lock
);
    localparam int NDB = 3;

    logic          db_raw  [NDB];
    logic [CW-1:0] db_rise [NDB];
    logic [CW-1:0] db_fall [NDB];
    logic [NDB-1:0] db_out;

    // Map the filtered sources onto the debouncer slots.
    always_comb begin
        db_raw[0]  = !pwrbtn_n;
        db_rise[0] = cfg_lpk_ms;
        db_fall[0] = '0;
        db_raw[1]  = pdn_pin;
        db_rise[1] = cfg_pdn_db_ms;
        db_fall[1] = cfg_pdn_db_ms;
        db_raw[2]  = !reset_in_n;
        db_rise[2] = CW'(RST_ASSERT_MS);
        db_fall[2] = CW'(RST_RELEASE_MS);
    end

    for (genvar g = 0; g < NDB; g++) begin : g_db
        pwroff_debounce #(.CW(CW)) u_db (
            .clk     (clk),
            .rst_n   (rst_n),
            .ms_tick (ms_tick),
            .raw     (db_raw[g]),
            .rise_ms (db_rise[g]),
            .fall_ms (db_fall[g]),
            .filt    (db_out[g])
        );
    end

    // Watchdog enable register; writes are refused once the lock is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdt_en   <= 1'b0;
            wdt_lock <= 1'b0;
        end else begin
            if (wdt_en_wr && !wdt_lock) wdt_en <= wdt_en_val;
            if (wdt_lock_wr)            wdt_lock <= 1'b1;
        end
    end

    // Assemble the qualified request vector in priority order.
    always_comb begin
        qreq              = '0;
        qreq[SRC_THERM]   = thermal_sd;
        qreq[SRC_SWRST]   = sw_rst_bit;
        qreq[SRC_VSYS]    = vsys_low;
        qreq[SRC_KEEP]    = !dev_on_bit && !hold_pin;
        qreq[SRC_BTN]     = db_out[0];
        qreq[SRC_PDPIN]   = db_out[1];
        qreq[SRC_WDT]     = wdt_expire && wdt_en;
        qreq[SRC_RSTPIN]  = db_out[2];
        qreq[SRC_ADC]     = adc_sd && !cfg_adc_mask;
    end
endmodule

// File: rtl/pwroff_seq.sv
// Priority selection, switch-off delay and power-down/up handshake.
// It assumes cur_state reflects the external sequencer and that urgent
// sources sit at codes below N_IMM.
module pwroff_seq import pwroff_pkg::*; #(
    parameter int MS_PER_S = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic [1:0]       cur_state,
    input  logic             on_gate,
    input  logic [NREQ-1:0]  qreq,
    input  logic [1:0]       cfg_dly_sel,
    input  logic [NREQ-1:0]  cfg_wide,
    input  logic [NREQ-1:0]  cfg_restart,
    output logic             pwrdn_start,
    output logic             pwrup_start,
    output logic             wide_rst,
    output logic [SRC_W-1:0] win_src,
    output logic             on_allow
);
    localparam int DW = $clog2(4 * MS_PER_S + 2);

    seq_e            state;
    logic [DW-1:0]   cnt;
    logic [DW-1:0]   tgt;
    logic [DW:0]     cnt_nxt;
    logic [SRC_W-1:0] win;
    logic            any_req;
    logic            any_imm;
    logic            win_imm;
    logic            cur_live;
    logic            restart_q;
    logic [NREQ-1:0] wide_eff;
    logic [NREQ-1:0] restart_eff;

    // Fixed-priority encoder: the lowest set code wins.
    always_comb begin
        win = '0;
        for (int i = NREQ - 1; i >= 0; i--) begin
            if (qreq[i]) win = SRC_W'(i);
        end
        any_req = |qreq;
        any_imm = |qreq[N_IMM-1:0];
        win_imm = (win < SRC_W'(N_IMM));
    end

    // Derived controls: delay target, live state, forced keep-alive config.
    always_comb begin
        case (cfg_dly_sel)
            2'd0:    tgt = '0;
            2'd1:    tgt = DW'(MS_PER_S);
            2'd2:    tgt = DW'(2 * MS_PER_S);
            default: tgt = DW'(4 * MS_PER_S);
        endcase
        cnt_nxt  = {1'b0, cnt} + 1'b1;
        cur_live = (cur_state == PS_ACTIVE) || (cur_state == PS_SLEEP);
        wide_eff              = cfg_wide;
        wide_eff[SRC_KEEP]    = 1'b0;
        restart_eff           = cfg_restart;
        restart_eff[SRC_KEEP] = 1'b0;
    end

    // Main sequencer: select, delay, power down, wait for release, restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= SQ_IDLE;
            cnt         <= '0;
            win_src     <= '0;
            wide_rst    <= 1'b0;
            restart_q   <= 1'b0;
            pwrdn_start <= 1'b0;
            pwrup_start <= 1'b0;
        end else begin
            pwrdn_start <= 1'b0;
            pwrup_start <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (cur_live && any_req) begin
                        win_src   <= win;
                        wide_rst  <= wide_eff[win];
                        restart_q <= restart_eff[win];
                        cnt       <= '0;
                        if (win_imm || (tgt == '0)) begin
                            pwrdn_start <= 1'b1;
                            state       <= SQ_PDN;
                        end else begin
                            state <= SQ_WAIT;
                        end
                    end
                end
                SQ_WAIT: begin
                    if (!cur_live) begin
                        state <= SQ_IDLE;
                    end else if (any_imm) begin
                        win_src     <= win;
                        wide_rst    <= wide_eff[win];
                        restart_q   <= restart_eff[win];
                        pwrdn_start <= 1'b1;
                        state       <= SQ_PDN;
                    end else if (!qreq[win_src]) begin
                        state <= SQ_IDLE;
                    end else if (ms_tick) begin
                        if (cnt_nxt >= {1'b0, tgt}) begin
                            pwrdn_start <= 1'b1;
                            state       <= SQ_PDN;
                        end else begin
                            cnt <= cnt_nxt[DW-1:0];
                        end
                    end
                end
                SQ_PDN: begin
                    if (cur_state == PS_OFF) state <= SQ_OFFW;
                end
                SQ_OFFW: begin
                    if (!qreq[win_src]) state <= restart_q ? SQ_RSTW : SQ_IDLE;
                end
                SQ_RSTW: begin
                    if (!on_gate) begin
                        pwrup_start <= 1'b1;
                        state       <= SQ_IDLE;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign on_allow = (state == SQ_IDLE);
endmodule

// File: rtl/pwroff_arb.sv
// Top of the power-off arbiter: qualification followed by sequencing.
// Assumes one ms_tick pulse per millisecond and synchronous inputs.
module pwroff_arb import pwroff_pkg::*; #(
    parameter int MS_PER_S       = 1000,
    parameter int CW             = 8,
    parameter int RST_ASSERT_MS  = 1,
    parameter int RST_RELEASE_MS = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic [1:0]       cur_state,
    input  logic             on_gate,
    input  logic             thermal_sd,
    input  logic             sw_rst_bit,
    input  logic             vsys_low,
    input  logic             dev_on_bit,
    input  logic             hold_pin,
    input  logic             pwrbtn_n,
    input  logic             pdn_pin,
    input  logic             wdt_expire,
    input  logic             reset_in_n,
    input  logic             adc_sd,
    input  logic [1:0]       cfg_dly_sel,
    input  logic [CW-1:0]    cfg_lpk_ms,
    input  logic [CW-1:0]    cfg_pdn_db_ms,
    input  logic             cfg_adc_mask,
    input  logic [NREQ-1:0]  cfg_wide,
    input  logic [NREQ-1:0]  cfg_restart,
    input  logic             wdt_en_wr,
    input  logic             wdt_en_val,
    input  logic             wdt_lock_wr,
    output logic             pwrdn_start,
    output logic             pwrup_start,
    output logic             wide_rst,
    output logic [SRC_W-1:0] win_src,
    output logic             on_allow
);
    logic [NREQ-1:0] qreq;
    logic            wdt_en_w;
    logic            wdt_lock_w;

    pwroff_qual #(
        .CW             (CW),
        .RST_ASSERT_MS  (RST_ASSERT_MS),
        .RST_RELEASE_MS (RST_RELEASE_MS)
    ) u_qual (
        .clk           (clk),
        .rst_n         (rst_n),
        .ms_tick       (ms_tick),
        .thermal_sd    (thermal_sd),
        .sw_rst_bit    (sw_rst_bit),
        .vsys_low      (vsys_low),
        .dev_on_bit    (dev_on_bit),
        .hold_pin      (hold_pin),
        .pwrbtn_n      (pwrbtn_n),
        .pdn_pin       (pdn_pin),
        .wdt_expire    (wdt_expire),
        .reset_in_n    (reset_in_n),
        .adc_sd        (adc_sd),
        .cfg_lpk_ms    (cfg_lpk_ms),
        .cfg_pdn_db_ms (cfg_pdn_db_ms),
        .cfg_adc_mask  (cfg_adc_mask),
        .wdt_en_wr     (wdt_en_wr),
        .wdt_en_val    (wdt_en_val),
        .wdt_lock_wr   (wdt_lock_wr),
        .qreq          (qreq),
        .wdt_en        (wdt_en_w),
        .wdt_lock      (wdt_lock_w)
    );

    pwroff_seq #(.MS_PER_S(MS_PER_S)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ms_tick     (ms_tick),
        .cur_state   (cur_state),
        .on_gate     (on_gate),
        .qreq        (qreq),
        .cfg_dly_sel (cfg_dly_sel),
        .cfg_wide    (cfg_wide),
        .cfg_restart (cfg_restart),
        .pwrdn_start (pwrdn_start),
        .pwrup_start (pwrup_start),
        .wide_rst    (wide_rst),
        .win_src     (win_src),
        .on_allow    (on_allow)
    );
endmodule

// File: rtl/pwroff_arb_chk.sv
// Temporal checks on the arbiter's outputs and watchdog lock state.
module pwroff_arb_chk import pwroff_pkg::*; (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       cur_state,
    input logic             on_gate,
    input logic             pwrdn_start,
    input logic             pwrup_start,
    input logic             wide_rst,
    input logic [SRC_W-1:0] win_src,
    input logic             wdt_en,
    input logic             wdt_lock
);
    a_r12_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwrdn_start && pwrup_start));

    a_r12_pdn_single: assert property (@(posedge clk) disable iff (!rst_n)
        pwrdn_start |=> !pwrdn_start);

    a_r1_live_only: assert property (@(posedge clk) disable iff (!rst_n)
        pwrdn_start |-> ($past(cur_state) == PS_ACTIVE || $past(cur_state) == PS_SLEEP));

    a_r10_up_ungated: assert property (@(posedge clk) disable iff (!rst_n)
        pwrup_start |-> !$past(on_gate));

    a_r5_keep_limited: assert property (@(posedge clk) disable iff (!rst_n)
        (pwrdn_start && win_src == SRC_W'(SRC_KEEP)) |-> !wide_rst);

    a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_lock |=> (wdt_lock && $stable(wdt_en)));
endmodule

bind pwroff_arb pwroff_arb_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cur_state   (cur_state),
    .on_gate     (on_gate),
    .pwrdn_start (pwrdn_start),
    .pwrup_start (pwrup_start),
    .wide_rst    (wide_rst),
    .win_src     (win_src),
    .wdt_en      (wdt_en_w),
    .wdt_lock    (wdt_lock_w)
);

// File: tb/pwroff_arb_tb_top.sv
// Self-checking bench with a short second (4 ticks) for fast sweeps.
module pwroff_arb_tb_top;
    localparam int MSS = 4;
    localparam int CW  = 8;
    localparam int NR  = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 1'b0;
    logic [1:0] cur_state = 2'b01;
    logic on_gate = 1'b0;
    logic thermal_sd = 0, sw_rst_bit = 0, vsys_low = 0;
    logic dev_on_bit = 1, hold_pin = 1, pwrbtn_n = 1, pdn_pin = 0;
    logic wdt_expire = 0, reset_in_n = 1, adc_sd = 0;
    logic [1:0] cfg_dly_sel = 2'd0;
    logic [CW-1:0] cfg_lpk_ms = 8'd3, cfg_pdn_db_ms = 8'd0;
    logic cfg_adc_mask = 1'b0;
    logic [NR-1:0] cfg_wide = '0, cfg_restart = '0;
    logic wdt_en_wr = 0, wdt_en_val = 0, wdt_lock_wr = 0;
    logic pwrdn_start, pwrup_start, wide_rst, on_allow;
    logic [3:0] win_src;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    pwroff_arb #(.MS_PER_S(MSS), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .cur_state(cur_state),
        .on_gate(on_gate), .thermal_sd(thermal_sd), .sw_rst_bit(sw_rst_bit),
        .vsys_low(vsys_low), .dev_on_bit(dev_on_bit), .hold_pin(hold_pin),
        .pwrbtn_n(pwrbtn_n), .pdn_pin(pdn_pin), .wdt_expire(wdt_expire),
        .reset_in_n(reset_in_n), .adc_sd(adc_sd), .cfg_dly_sel(cfg_dly_sel),
        .cfg_lpk_ms(cfg_lpk_ms), .cfg_pdn_db_ms(cfg_pdn_db_ms),
        .cfg_adc_mask(cfg_adc_mask), .cfg_wide(cfg_wide),
        .cfg_restart(cfg_restart), .wdt_en_wr(wdt_en_wr),
        .wdt_en_val(wdt_en_val), .wdt_lock_wr(wdt_lock_wr),
        .pwrdn_start(pwrdn_start), .pwrup_start(pwrup_start),
        .wide_rst(wide_rst), .win_src(win_src), .on_allow(on_allow)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_src(int s, logic v);
        case (s)
            0: thermal_sd = v;
            1: sw_rst_bit = v;
            2: vsys_low = v;
            3: begin dev_on_bit = !v; hold_pin = !v; end
            4: pwrbtn_n = !v;
            5: pdn_pin = v;
            6: wdt_expire = v;
            7: reset_in_n = !v;
            default: adc_sd = v;
        endcase
    endtask

    // Plain steps; reports whether the watched pulse was seen.
    task automatic settle(int n, logic up, output logic seen);
        seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            step();
            if (up ? pwrup_start : pwrdn_start) seen = 1'b1;
        end
    endtask

    // Tick n times (one tick step, two plain steps each); first tick seen.
    task automatic run_ticks(int n, logic up, output int at);
        at = -1;
        for (int i = 1; i <= n; i++) begin
            ms_tick = 1'b1;
            step();
            if (at < 0 && (up ? pwrup_start : pwrdn_start)) at = i;
            ms_tick = 1'b0;
            for (int k = 0; k < 2; k++) begin
                step();
                if (at < 0 && (up ? pwrup_start : pwrdn_start)) at = i;
            end
        end
    endtask

    task automatic cleanup(int s);
        int d;
        cur_state = 2'b00;
        step();
        set_src(s, 1'b0);
        run_ticks(3, 1'b0, d);
        cur_state = 2'b01;
        step();
    endtask

    initial begin
        logic seen;
        int at;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R12 reset pwrdn", pwrdn_start, 0);
        chk("R12 reset pwrup", pwrup_start, 0);
        chk("R10 reset on_allow", on_allow, 1);

        // R1/R4: urgent sources, all wide/restart combinations, ACTIVE and SLEEP.
        for (int s = 0; s < 3; s++) begin
            for (int c = 0; c < 4; c++) begin
                cfg_wide    = {NR{c[0]}};
                cfg_restart = {NR{c[1]}};
                cur_state   = c[1] ? 2'b10 : 2'b01;
                on_gate     = 1'b0;
                set_src(s, 1'b1);
                step();
                chk("R1 urgent fires", pwrdn_start, 1);
                chk("R3 code", win_src, s);
                chk("R4 wide level", wide_rst, c[0]);
                cur_state = 2'b00;
                step();
                chk("R10 on_allow held", on_allow, 0);
                set_src(s, 1'b0);
                step();
                step();
                chk("R4 restart choice", pwrup_start, c[1]);
                step();
                cur_state = 2'b01;
                step();
            end
        end
        cfg_wide = '0;
        cfg_restart = '0;

        // R1: nothing starts from OFF.
        cur_state = 2'b00;
        set_src(0, 1'b1);
        settle(3, 1'b0, seen);
        chk("R1 no action in OFF", seen, 0);
        set_src(0, 1'b0);
        step();
        cur_state = 2'b01;
        step();

        // R2: delay sweep through the power-down pin.
        for (int d = 0; d < 4; d++) begin
            cfg_dly_sel = d[1:0];
            set_src(5, 1'b1);
            settle(3, 1'b0, seen);
            chk("R2 zero delay immediate", seen, (d == 0));
            if (d != 0) begin
                run_ticks(20, 1'b0, at);
                chk("R2 delay ticks", at, (d == 1) ? MSS : (d == 2) ? 2 * MSS : 4 * MSS);
            end
            cleanup(5);
        end
        cfg_dly_sel = 2'd0;

        // R2: power-down pin debounce of 2 ticks.
        cfg_pdn_db_ms = 8'd2;
        set_src(5, 1'b1);
        settle(3, 1'b0, seen);
        chk("R2 pin debounce holds", seen, 0);
        run_ticks(5, 1'b0, at);
        chk("R2 pin debounce ticks", at, 2);
        cleanup(5);
        cfg_pdn_db_ms = 8'd0;

        // R3/R4: three sources together, then the next in line takes over.
        cfg_wide = 9'b0_0010_0000;
        set_src(8, 1'b1);
        set_src(5, 1'b1);
        set_src(2, 1'b1);
        settle(2, 1'b0, seen);
        chk("R3 stacked fires", seen, 1);
        chk("R3 lowest code wins", win_src, 2);
        chk("R4 per-source wide", wide_rst, 0);
        cur_state = 2'b00;
        step();
        set_src(2, 1'b0);
        repeat (3) step();
        cur_state = 2'b01;
        step();
        chk("R3 next in line fires", pwrdn_start, 1);
        chk("R3 next code", win_src, 5);
        chk("R4 next wide", wide_rst, 1);
        set_src(8, 1'b0);
        cleanup(5);
        cfg_wide = '0;

        // R6: long press of 3 ticks.
        cfg_lpk_ms = 8'd3;
        set_src(4, 1'b1);
        settle(3, 1'b0, seen);
        chk("R6 short press ignored", seen, 0);
        run_ticks(6, 1'b0, at);
        chk("R6 long press ticks", at, 3);
        chk("R3 button code", win_src, 4);
        cleanup(4);

        // R7: reset pin, 1 tick to assert, 26 ticks to release, restart.
        cfg_restart = 9'b1_0000_0000 >> 1;
        set_src(7, 1'b1);
        settle(3, 1'b0, seen);
        chk("R7 needs a tick", seen, 0);
        run_ticks(3, 1'b0, at);
        chk("R7 assert ticks", at, 1);
        cur_state = 2'b00;
        step();
        set_src(7, 1'b0);
        run_ticks(30, 1'b1, at);
        chk("R7 release ticks", at, 26);
        cur_state = 2'b01;
        step();
        cfg_restart = '0;

        // R5: keep-alive needs both holders released; forced config.
        cfg_wide = '1;
        cfg_restart = '1;
        dev_on_bit = 1'b0;
        settle(3, 1'b0, seen);
        chk("R5 pin still holds", seen, 0);
        dev_on_bit = 1'b1;
        hold_pin = 1'b0;
        settle(3, 1'b0, seen);
        chk("R5 bit still holds", seen, 0);
        dev_on_bit = 1'b0;
        step();
        chk("R5 both released fires", pwrdn_start, 1);
        chk("R5 code", win_src, 3);
        chk("R5 limited level", wide_rst, 0);
        cur_state = 2'b00;
        step();
        hold_pin = 1'b1;
        settle(4, 1'b1, seen);
        chk("R5 no restart", seen, 0);
        dev_on_bit = 1'b1;
        cur_state = 2'b01;
        step();
        cfg_wide = '0;

        // R10: restart waits for on_gate.
        on_gate = 1'b1;
        set_src(1, 1'b1);
        step();
        chk("R1 ungated by on_gate", pwrdn_start, 1);
        cur_state = 2'b00;
        step();
        set_src(1, 1'b0);
        settle(4, 1'b1, seen);
        chk("R10 gated restart held", seen, 0);
        on_gate = 1'b0;
        step();
        chk("R10 restart after gate", pwrup_start, 1);
        step();
        chk("R12 restart single", pwrup_start, 0);
        cur_state = 2'b01;
        step();
        cfg_restart = '0;

        // R8: ADC mask.
        cfg_adc_mask = 1'b1;
        set_src(8, 1'b1);
        run_ticks(3, 1'b0, at);
        chk("R8 masked ignored", at, -1);
        cfg_adc_mask = 1'b0;
        step();
        chk("R8 unmasked fires", pwrdn_start, 1);
        chk("R3 adc code", win_src, 8);
        cleanup(8);

        // R9: watchdog default off, enable, lock, locked write ignored.
        set_src(6, 1'b1);
        run_ticks(2, 1'b0, at);
        chk("R9 disabled by default", at, -1);
        set_src(6, 1'b0);
        wdt_en_wr = 1'b1; wdt_en_val = 1'b1; wdt_lock_wr = 1'b1;
        step();
        wdt_en_val = 1'b0; wdt_lock_wr = 1'b0;
        step();
        wdt_en_wr = 1'b0;
        set_src(6, 1'b1);
        step();
        chk("R9 locked enable fires", pwrdn_start, 1);
        chk("R3 wdt code", win_src, 6);
        cleanup(6);

        // R11: urgent source on the final delay tick overrides.
        cfg_dly_sel = 2'd1;
        cfg_wide = 9'b0_0000_0001;
        set_src(5, 1'b1);
        settle(3, 1'b0, seen);
        run_ticks(MSS - 1, 1'b0, at);
        chk("R11 delay still running", at, -1);
        ms_tick = 1'b1;
        thermal_sd = 1'b1;
        step();
        ms_tick = 1'b0;
        chk("R11 fires on coincidence", pwrdn_start, 1);
        chk("R11 urgent code", win_src, 0);
        chk("R11 urgent level", wide_rst, 1);
        thermal_sd = 1'b0;
        cleanup(5);

        // R11: withdrawn delayed source cancels.
        set_src(5, 1'b1);
        settle(3, 1'b0, seen);
        run_ticks(2, 1'b0, at);
        set_src(5, 1'b0);
        run_ticks(6, 1'b0, at);
        chk("R11 withdrawn cancels", at, -1);
        chk("R10 idle on_allow", on_allow, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule